// File: doc/BRIEF.md
# Floating-point exception and trap status unit

This unit holds the exception-related fields of a floating-point status register. After each arithmetic operation it takes five IEEE exception flags and folds them into the current-exception field. If a raised exception is also enabled, it issues a one-cycle trap request with a fixed trap type. Otherwise it merges the current exceptions into the accrued field.

Software can load the register through a 32-bit or a 64-bit path. Each path writes only the bits under its own writable mask and keeps the other bits. The unit also decodes the rounding-direction field into a one-hot mode vector for the arithmetic units.

Top module: `fpu_exc_status`

## Requirements
- R1: After reset, `status` is all zeros, `trap_req` is 0, `trap_type` is 0 and `rnd_mode` is 4'b0001 (nearest).
- R2: On `op_valid` with nonzero `op_flags`, the current-exception field `status[4:0]` becomes its old value ORed with the flags. The flag bits, from bit 4 down to bit 0, are invalid, overflow, underflow, divide-by-zero and inexact.
- R3: When the new current-exception field ANDed with the trap-enable field `status[27:23]` is nonzero, `trap_req` is 1 for exactly the cycle after the operation strobe. In that cycle `trap_type` equals `TRAP_CODE` (default 8'h21). In every other cycle `trap_req` is 0 and `trap_type` is 0.
- R4: On a trap, the trap-type field `status[16:14]` becomes 3'd1 and the accrued field `status[9:5]` is left unchanged.
- R5: When an operation raises flags but does not trap, the accrued field `status[9:5]` becomes its old value ORed with the new current-exception field.
- R6: An operation strobe with all five flags zero leaves `status` unchanged and raises no trap.
- R7: A 32-bit load sets `status` to (`ld32_data` & `LD32_MASK`) | (old & ~`LD32_MASK`), with `ld32_data` zero-extended. The default mask is 32'hCF8003FF, so bits 63:32 are always kept.
- R8: A 64-bit load sets `status` to (`ld64_data` & `LD64_MASK`) | (old & ~`LD64_MASK`). The default mask is 64'h0000003FCF8003FF.
- R9: A 64-bit load takes priority over a 32-bit load, and either load takes priority over an operation strobe in the same cycle. An overridden operation raises no trap.
- R10: `rnd_mode` is one-hot, decoded from `status[31:30]`: code 0 gives bit 0 (nearest even), code 1 gives bit 1 (toward zero), code 2 gives bit 2 (toward plus infinity) and code 3 gives bit 3 (toward minus infinity).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation finished; sample `op_flags` |
| op_flags | input | 5 | Exception flags raised by the operation |
| ld32_valid | input | 1 | 32-bit software load strobe |
| ld32_data | input | 32 | 32-bit load value |
| ld64_valid | input | 1 | 64-bit software load strobe |
| ld64_data | input | SW (64) | 64-bit load value |
| status | output | SW (64) | Current status register |
| trap_req | output | 1 | One-cycle trap request |
| trap_type | output | TTW (8) | Trap type, valid while `trap_req` is 1 |
| rnd_mode | output | 4 | One-hot rounding direction |

## Verification
All state is in `status`, so any wrong update shows at the ports on the next cycle. A bad merge shows as an accrued bit that is wrongly set or missing, or as current-exception bits that are wrong. A missed or spurious trap shows in the same cycle as `trap_req`. A wrong trap-enable alignment also shows as wrong values in the `status` fields. The sweep covers all 32 flag sets against all 32 enable sets from a clean state, so every pairing of flags and enables gets its own check.

// File: rtl/fpu_exc_status.sv
`timescale 1ns/100ps
module fpu_exc_status #(
  parameter int SW = 64,
  parameter int TTW = 8,
  parameter logic [TTW-1:0] TRAP_CODE = 8'h21,
  parameter logic [31:0] LD32_MASK = 32'hCF8003FF,
  parameter logic [SW-1:0] LD64_MASK = 64'h0000003FCF8003FF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [4:0]     op_flags,
  input  logic           ld32_valid,
  input  logic [31:0]    ld32_data,
  input  logic           ld64_valid,
  input  logic [SW-1:0]  ld64_data,
  output logic [SW-1:0]  status,
  output logic           trap_req,
  output logic [TTW-1:0] trap_type,
  output logic [3:0]     rnd_mode
);
  localparam int NF = 5;
  localparam int CX = 0;
  localparam int AX = CX + NF;
  localparam int TE = CX + 23;
  localparam int TT = 14;
  localparam int RD = 30;

  logic [SW-1:0] st, nxt;
  logic          trap_n;

  wire [SW-1:0] m32   = {{(SW-32){1'b0}}, LD32_MASK};
  wire [SW-1:0] d32   = {{(SW-32){1'b0}}, ld32_data};
  wire [NF-1:0] cnew  = st[CX +: NF] | op_flags;
  wire          hit   = |(cnew & st[TE +: NF]);

  always_comb begin
    nxt    = st;
    trap_n = 1'b0;
    if (ld64_valid)
      nxt = (ld64_data & LD64_MASK) | (st & ~LD64_MASK);
    else if (ld32_valid)
      nxt = (d32 & m32) | (st & ~m32);
    else if (op_valid && |op_flags) begin
      nxt[CX +: NF] = cnew;
      if (hit) begin
        nxt[TT +: 3] = 3'd1;
        trap_n = 1'b1;
      end else
        nxt[AX +: NF] = st[AX +: NF] | cnew;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= '0;
      trap_req  <= 1'b0;
      trap_type <= '0;
    end else begin
      st        <= nxt;
      trap_req  <= trap_n;
      trap_type <= trap_n ? TRAP_CODE : '0;
    end
  end

  always_comb begin
    case (st[RD +: 2])
      2'd0:    rnd_mode = 4'b0001;
      2'd1:    rnd_mode = 4'b0010;
      2'd2:    rnd_mode = 4'b0100;
      2'd3:    rnd_mode = 4'b1000;
      default: rnd_mode = 4'b0010;
    endcase
  end

  assign status = st;
endmodule

// File: rtl/fpu_exc_status_chk.sv
`timescale 1ns/100ps
module fpu_exc_status_chk #(
  parameter int SW = 64,
  parameter int TTW = 8,
  parameter logic [TTW-1:0] TRAP_CODE = 8'h21,
  parameter logic [31:0] LD32_MASK = 32'hCF8003FF,
  parameter logic [SW-1:0] LD64_MASK = 64'h0000003FCF8003FF
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [4:0]     op_flags,
  input logic           ld32_valid,
  input logic           ld64_valid,
  input logic [SW-1:0]  status,
  input logic           trap_req,
  input logic [TTW-1:0] trap_type,
  input logic [3:0]     rnd_mode
);
  wire [SW-1:0] m32 = {{(SW-32){1'b0}}, LD32_MASK};
  wire          ld  = ld32_valid | ld64_valid;

  a_r3_trap_after_op: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(op_valid) && trap_type == TRAP_CODE);

  a_r4_trap_keeps_accrued: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> status[16:14] == 3'd1 && status[9:5] == $past(status[9:5]));

  a_r6_no_flags_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_flags == 5'd0 && !ld) |=> $stable(status) && !trap_req);

  a_r7_ld32_keeps_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (ld32_valid && !ld64_valid) |=> ((status ^ $past(status)) & ~m32) == '0);

  a_r8_ld64_keeps_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    ld64_valid |=> ((status ^ $past(status)) & ~LD64_MASK) == '0);

  a_r9_load_blocks_trap: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !trap_req);

  a_r10_round_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rnd_mode) == 1);
endmodule

bind fpu_exc_status fpu_exc_status_chk #(
  .SW(SW), .TTW(TTW), .TRAP_CODE(TRAP_CODE),
  .LD32_MASK(LD32_MASK), .LD64_MASK(LD64_MASK)
) chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
  .ld32_valid(ld32_valid), .ld64_valid(ld64_valid), .status(status),
  .trap_req(trap_req), .trap_type(trap_type), .rnd_mode(rnd_mode)
);

// File: tb/fpu_exc_status_test.sv
`timescale 1ns/100ps
module fpu_exc_status_test;
  localparam logic [31:0] M32 = 32'hCF8003FF;
  localparam logic [63:0] M64 = 64'h0000003FCF8003FF;
  localparam logic [7:0]  TC  = 8'h21;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 1'b0, ld32_valid = 1'b0, ld64_valid = 1'b0;
  logic [4:0]  op_flags = '0;
  logic [31:0] ld32_data = '0;
  logic [63:0] ld64_data = '0;
  logic [63:0] status;
  logic        trap_req;
  logic [7:0]  trap_type;
  logic [3:0]  rnd_mode;

  int   errors = 0, checks = 0;
  bit   done = 1'b0;
  logic [63:0] e;

  always #2.5 clk = ~clk;

  fpu_exc_status uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
    .ld32_valid(ld32_valid), .ld32_data(ld32_data),
    .ld64_valid(ld64_valid), .ld64_data(ld64_data),
    .status(status), .trap_req(trap_req), .trap_type(trap_type),
    .rnd_mode(rnd_mode)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ld64(input logic [63:0] d);
    @(negedge clk); ld64_valid = 1'b1; ld64_data = d;
    @(negedge clk); ld64_valid = 1'b0;
    e = (d & M64) | (e & ~M64);
    chk("R8 ld64 status", status, e);
  endtask

  task automatic ld32(input logic [31:0] d);
    @(negedge clk); ld32_valid = 1'b1; ld32_data = d;
    @(negedge clk); ld32_valid = 1'b0;
    e = ({32'd0, d} & {32'd0, M32}) | (e & ~{32'd0, M32});
    chk("R7 ld32 status", status, e);
  endtask

  task automatic op(input logic [4:0] f);
    logic [4:0] c;
    logic       t;
    @(negedge clk); op_valid = 1'b1; op_flags = f;
    @(negedge clk); op_valid = 1'b0;
    t = 1'b0;
    if (f != 5'd0) begin
      c = e[4:0] | f;
      e[4:0] = c;
      if ((c & e[27:23]) != 5'd0) begin
        e[16:14] = 3'd1;
        t = 1'b1;
      end else
        e[9:5] = e[9:5] | c;
    end
    chk(f == 5'd0 ? "R6 zero flags status" : (t ? "R4 trap status" : "R5 accrue status"), status, e);
    chk("R3 trap_req", {63'd0, trap_req}, {63'd0, t});
    chk("R3 trap_type", {56'd0, trap_type}, t ? {56'd0, TC} : 64'd0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    e = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 64'd0);
    chk("R1 reset trap_req", {63'd0, trap_req}, 64'd0);
    chk("R1 reset trap_type", {56'd0, trap_type}, 64'd0);
    chk("R1 reset rnd_mode", {60'd0, rnd_mode}, 64'd1);

    // R2 R3 R4 R5: every flag set against every enable set from a clean state
    for (int en = 0; en < 32; en++)
      for (int fl = 0; fl < 32; fl++) begin
        ld64(64'(en) << 23);
        op(5'(fl));
      end

    // R2: flags OR into existing current exceptions, no enables
    ld64(64'h0000_0000_0000_0002);
    op(5'b00001);
    chk("R2 cexc or", {59'd0, status[4:0]}, 64'd3);
    op(5'b10000);
    chk("R2 cexc or again", {59'd0, status[4:0]}, 64'h13);

    // R6: zero flags
    op(5'd0);

    // R7: 32-bit load keeps unmasked bits including the upper word
    ld64(64'hFFFF_FFFF_FFFF_FFFF);
    ld32(32'h0000_0000);
    ld32(32'hFFFF_FFFF);
    ld32(32'h5A5A_A5A5);

    // R8: 64-bit load mask merge
    ld64(64'h0123_4567_89AB_CDEF);
    ld64(64'h0);

    // R10: rounding decode
    for (int r = 0; r < 4; r++) begin
      ld32(32'(r) << 30);
      chk("R10 rnd_mode", {60'd0, rnd_mode}, 64'(1) << r);
    end

    // R9: load wins over op, ld64 wins over ld32
    ld64(64'h0F80_0000);
    @(negedge clk);
    ld32_valid = 1'b1; ld32_data = 32'h4000_0000; op_valid = 1'b1; op_flags = 5'h1F;
    @(negedge clk);
    ld32_valid = 1'b0; op_valid = 1'b0;
    e = (64'h4000_0000 & {32'd0, M32}) | (e & ~{32'd0, M32});
    chk("R9 ld32 over op status", status, e);
    chk("R9 ld32 over op trap", {63'd0, trap_req}, 64'd0);
    @(negedge clk);
    ld64_valid = 1'b1; ld64_data = 64'h8000_0001; ld32_valid = 1'b1; ld32_data = 32'h0000_03FF;
    @(negedge clk);
    ld64_valid = 1'b0; ld32_valid = 1'b0;
    e = (64'h8000_0001 & M64) | (e & ~M64);
    chk("R9 ld64 over ld32 status", status, e);
    chk("R10 rnd after ld64", {60'd0, rnd_mode}, 64'd4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule